// File: doc/BRIEF.md
# Set-Associative Branch Target Cache

This block remembers branch target addresses. Each time a taken branch resolves, the pipeline presents the target address together with a one-cycle request pulse. The block picks a set from the low-order bits of the target address and compares the full address with the tag of every way in that set. One cycle later it returns a registered hit or miss flag. On a miss the address is written into a victim way, and the instruction-block field attached to that way is cleared. The field is a placeholder for instruction bytes that could be fetched ahead at the target later. On a hit, the stored block field of the matching way is returned.

Replacement uses a small usage counter in every way and an aging scheme. Each accepted access first decrements every nonzero counter in the addressed set. It then loads the accessed way with the highest usage value. Two event counters record hits and misses. A global enable input freezes the block: while it is low, requests are not answered and neither the array nor the counters change. The geometry, counter range, block size and counter width are all parameters.

Top module: `brtgt_cache`

## Requirements
- R1: After reset every way is invalid, all usage counters are 0, and rsp_vld_o, hit_o, blk_o, hit_cnt_o and miss_cnt_o read 0.
- R2: A request sampled at a clock edge with en_i high raises rsp_vld_o for exactly the following cycle. A cycle without an accepted request leaves rsp_vld_o low.
- R3: The set index is addr_i modulo SETS (the low log2(SETS) address bits). hit_o is 1 exactly when a valid way of that set holds a tag equal to the full addr_i.
- R4: A missing address is allocated, so an immediate repeat request for the same address hits.
- R5: When the set contains an invalid way, the victim is the lowest-numbered invalid way, and valid entries of the set are kept.
- R6: When every way of the set is valid, the victim is the way with the smallest usage counter, with ties going to the lowest way number.
- R7: On every accepted access, each way of the addressed set with a nonzero usage counter decrements by one. The accessed way (the hit way, or the newly filled way) is then set to USTATES-1.
- R8: Allocation clears the way's 8*BLK_BYTES-bit block field. blk_o returns the hit way's block field on a hit and 0 on a miss, so it reads 0 on every response.
- R9: hit_cnt_o increments by one for each accepted hit and miss_cnt_o by one for each accepted miss, updating on the same edge that produces the response.
- R10: While en_i is low, a request changes nothing: there is no response, the counters stay unchanged, and the address is not allocated (a later enabled request for it misses).
- R11: An access to one set changes neither the contents nor the usage counters of any other set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Block enable; low suppresses updates and statistics |
| req_i | input | 1 | One-cycle lookup/update request |
| addr_i | input | AW | Branch target address |
| rsp_vld_o | output | 1 | Response valid, one cycle after an accepted request |
| hit_o | output | 1 | Lookup result, meaningful while rsp_vld_o is high |
| blk_o | output | 8*BLK_BYTES | Block field of the hit way, 0 on a miss |
| hit_cnt_o | output | CW | Number of accepted hits |
| miss_cnt_o | output | CW | Number of accepted misses |

## Verification
Two things happen at the same edge. A miss fills the victim way, and the aging logic decrements the other ways of that set. The bench provokes this by sending directed series of three target addresses that share one set, and random traffic drawn from a small pool of tags and indices. Both changes are judged through later responses: the next requests for the evicted and the kept addresses must miss and hit as a reference model predicts. The same edge also carries the request itself and the counter update, so every response is checked against the counter values expected after that request.

// File: rtl/btc_pkg.sv
package btc_pkg;

   // Kind of access performed in a cycle.
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_HIT  = 2'd1,
      ACC_MISS = 2'd2
   } acc_e;

   // Index width that is never zero, so single-entry dimensions still work.
   function automatic int unsigned clog2_min1(input int unsigned n);
      int unsigned r;
      r = (n > 1) ? $clog2(n) : 1;
      return r;
   endfunction

endpackage

// File: rtl/btc_match.sv
module btc_match #(
   parameter int AW   = 32,
   parameter int WAYS = 2,
   parameter int WIW  = 1
) (
   input  logic [WAYS*AW-1:0] tags_i,
   input  logic [WAYS-1:0]    vld_i,
   input  logic [AW-1:0]      addr_i,
   output logic               hit_o,
   output logic [WIW-1:0]     way_o
);
   logic [WAYS-1:0] eq;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign eq[w] = vld_i[w] && (tags_i[w*AW +: AW] == addr_i);
   end

   // Lowest matching way wins (a correct fill never creates duplicates).
   always_comb begin
      way_o = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (eq[w]) way_o = WIW'(w);
      end
   end

   assign hit_o = |eq;
endmodule

// File: rtl/btc_victim.sv
module btc_victim #(
   parameter int WAYS = 2,
   parameter int UW   = 1,
   parameter int WIW  = 1
) (
   input  logic [WAYS-1:0]    vld_i,
   input  logic [WAYS*UW-1:0] use_i,
   output logic [WIW-1:0]     vic_o
);
   logic [WIW-1:0] inv_way;
   logic           any_inv;
   logic [WIW-1:0] min_way;
   logic [UW-1:0]  min_use;

   // Lowest-numbered invalid way.
   always_comb begin
      inv_way = '0;
      any_inv = 1'b0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!vld_i[w]) begin
            inv_way = WIW'(w);
            any_inv = 1'b1;
         end
      end
   end

   // Smallest usage counter; strict compare keeps the lowest way on ties.
   always_comb begin
      min_way = '0;
      min_use = use_i[UW-1:0];
      for (int w = 1; w < WAYS; w++) begin
         if (use_i[w*UW +: UW] < min_use) begin
            min_use = use_i[w*UW +: UW];
            min_way = WIW'(w);
         end
      end
   end

   assign vic_o = any_inv ? inv_way : min_way;
endmodule

// File: rtl/btc_evt_ctr.sv
module btc_evt_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_o <= '0;
      else if (inc_i) cnt_o <= cnt_o + W'(1);
   end
endmodule

// File: rtl/brtgt_cache.sv
module brtgt_cache
   import btc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int SETS      = 128,
   parameter int WAYS      = 2,
   parameter int USTATES   = 2,
   parameter int BLK_BYTES = 4,
   parameter int CW        = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_i,
   input  logic                   req_i,
   input  logic [AW-1:0]          addr_i,
   output logic                   rsp_vld_o,
   output logic                   hit_o,
   output logic [8*BLK_BYTES-1:0] blk_o,
   output logic [CW-1:0]          hit_cnt_o,
   output logic [CW-1:0]          miss_cnt_o
);
   localparam int IW  = clog2_min1(SETS);
   localparam int WIW = clog2_min1(WAYS);
   localparam int UW  = clog2_min1(USTATES);
   localparam int BW  = 8 * BLK_BYTES;
   localparam logic [UW-1:0] UMAX = UW'(USTATES - 1);

   // Elaboration-time parameter checks.
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("WAYS must be at least 1");
   end
   if (USTATES < 2) begin : g_bad_ustates
      $error("USTATES must be at least 2");
   end
   if (AW <= IW) begin : g_bad_aw
      $error("AW must exceed the set index width");
   end
   if (BLK_BYTES < 1 || CW < 1) begin : g_bad_misc
      $error("BLK_BYTES and CW must be positive");
   end

   // Storage.
   logic [AW-1:0] tag_q [SETS][WAYS];
   logic          val_q [SETS][WAYS];
   logic [UW-1:0] use_q [SETS][WAYS];
   logic [BW-1:0] blk_q [SETS][WAYS];

   logic [IW-1:0]      idx;
   logic [WAYS*AW-1:0] set_tags;
   logic [WAYS-1:0]    set_vld;
   logic [WAYS*UW-1:0] set_use;
   logic               hit;
   logic [WIW-1:0]     hit_way;
   logic [WIW-1:0]     vic_way;
   logic [WIW-1:0]     sel_way;
   acc_e               acc;

   assign idx = addr_i[IW-1:0];

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         set_tags[w*AW +: AW] = tag_q[idx][w];
         set_vld[w]           = val_q[idx][w];
         set_use[w*UW +: UW]  = use_q[idx][w];
      end
   end

   btc_match #(.AW(AW), .WAYS(WAYS), .WIW(WIW)) u_match (
      .tags_i (set_tags),
      .vld_i  (set_vld),
      .addr_i (addr_i),
      .hit_o  (hit),
      .way_o  (hit_way)
   );

   btc_victim #(.WAYS(WAYS), .UW(UW), .WIW(WIW)) u_victim (
      .vld_i (set_vld),
      .use_i (set_use),
      .vic_o (vic_way)
   );

   assign sel_way = hit ? hit_way : vic_way;

   always_comb begin
      if (!(en_i && req_i)) acc = ACC_IDLE;
      else if (hit)         acc = ACC_HIT;
      else                  acc = ACC_MISS;
   end

   // Array update: aging of the set, fill on miss.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w] <= '0;
               val_q[s][w] <= 1'b0;
               use_q[s][w] <= '0;
               blk_q[s][w] <= '0;
            end
         end
      end else if (acc != ACC_IDLE) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WIW'(w) == sel_way)     use_q[idx][w] <= UMAX;
            else if (use_q[idx][w] != '0) use_q[idx][w] <= use_q[idx][w] - UW'(1);
         end
         if (acc == ACC_MISS) begin
            tag_q[idx][sel_way] <= addr_i;
            val_q[idx][sel_way] <= 1'b1;
            blk_q[idx][sel_way] <= '0;
         end
      end
   end

   // Registered response.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld_o <= 1'b0;
         hit_o     <= 1'b0;
         blk_o     <= '0;
      end else begin
         rsp_vld_o <= (acc != ACC_IDLE);
         hit_o     <= (acc == ACC_HIT);
         blk_o     <= (acc == ACC_HIT) ? blk_q[idx][hit_way] : '0;
      end
   end

   btc_evt_ctr #(.W(CW)) u_hit_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (acc == ACC_HIT),
      .cnt_o (hit_cnt_o)
   );

   btc_evt_ctr #(.W(CW)) u_miss_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (acc == ACC_MISS),
      .cnt_o (miss_cnt_o)
   );
endmodule

// File: rtl/btc_chk.sv
module btc_chk #(
   parameter int BW = 32,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en_i,
   input logic          req_i,
   input logic          rsp_vld_o,
   input logic          hit_o,
   input logic [BW-1:0] blk_o,
   input logic [CW-1:0] hit_cnt_o,
   input logic [CW-1:0] miss_cnt_o
);
   // R2
   rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && req_i) |=> rsp_vld_o);

   // R2
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_i && req_i) |=> !rsp_vld_o);

   // R9
   hit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld_o && hit_o) |-> (hit_cnt_o == CW'($past(hit_cnt_o) + 1'b1)
                                && $stable(miss_cnt_o)));

   // R9
   miss_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld_o && !hit_o) |-> (miss_cnt_o == CW'($past(miss_cnt_o) + 1'b1)
                                 && $stable(hit_cnt_o)));

   // R10
   counts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld_o |-> ($stable(hit_cnt_o) && $stable(miss_cnt_o) && !hit_o));

   // R8
   blk_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld_o |-> (blk_o == '0));
endmodule

bind brtgt_cache btc_chk #(.BW(8*BLK_BYTES), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_i       (en_i),
   .req_i      (req_i),
   .rsp_vld_o  (rsp_vld_o),
   .hit_o      (hit_o),
   .blk_o      (blk_o),
   .hit_cnt_o  (hit_cnt_o),
   .miss_cnt_o (miss_cnt_o)
);

// File: tb/tb_brtgt_cache.sv
module tb_brtgt_cache;
   localparam int AW   = 32;
   localparam int SETS = 128;
   localparam int WAYS = 2;
   localparam int US   = 2;
   localparam int BW   = 32;
   localparam int CW   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          rsp_vld, hit;
   logic [BW-1:0] blk;
   logic [CW-1:0] hit_cnt, miss_cnt;

   brtgt_cache #(.AW(AW), .SETS(SETS), .WAYS(WAYS), .USTATES(US),
                 .BLK_BYTES(BW/8), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .req_i(req), .addr_i(addr),
      .rsp_vld_o(rsp_vld), .hit_o(hit), .blk_o(blk),
      .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt));

   always #5 clk = ~clk;

   // Reference model built from the requirements.
   logic [AW-1:0] m_tag [SETS][WAYS];
   bit            m_val [SETS][WAYS];
   int            m_use [SETS][WAYS];
   int            e_hit = 0, e_miss = 0;
   int            n_chk = 0, n_fail = 0;
   bit            done = 0;

   task automatic chk(input bit ok, input string r,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   function automatic int m_find(input logic [AW-1:0] a);
      int s = int'(a % SETS);
      for (int w = 0; w < WAYS; w++)
         if (m_val[s][w] && m_tag[s][w] == a) return w;
      return -1;
   endfunction

   // R5 lowest invalid first, R6 smallest usage with low-way tie-break.
   function automatic int m_victim(input int s);
      int best;
      for (int w = 0; w < WAYS; w++)
         if (!m_val[s][w]) return w;
      best = 0;
      for (int w = 1; w < WAYS; w++)
         if (m_use[s][w] < m_use[s][best]) best = w;
      return best;
   endfunction

   // One request at a negedge; response checked at the following negedge.
   task automatic access(input logic [AW-1:0] a, input bit e, input string r);
      int s = int'(a % SETS);
      int w = m_find(a);
      int sel;
      en = e; req = 1'b1; addr = a;
      if (e) begin
         sel = (w >= 0) ? w : m_victim(s);
         for (int k = 0; k < WAYS; k++) begin   // R7 aging
            if (k == sel) m_use[s][k] = US - 1;
            else if (m_use[s][k] > 0) m_use[s][k]--;
         end
         if (w < 0) begin
            m_tag[s][sel] = a; m_val[s][sel] = 1'b1; e_miss++;
         end else e_hit++;
      end
      @(negedge clk);
      req = 1'b0; en = 1'b1;
      chk(rsp_vld == e, {r, " R2 rsp_vld"}, rsp_vld, e);
      if (e) begin
         chk(hit == (w >= 0), {r, " R3 hit"}, hit, w >= 0);
         chk(blk == '0, {r, " R8 blk"}, blk, 0);
      end
      chk(hit_cnt == CW'(e_hit), {r, " R9 hit_cnt"}, hit_cnt, e_hit);
      chk(miss_cnt == CW'(e_miss), {r, " R9 miss_cnt"}, miss_cnt, e_miss);
   endtask

   task automatic idle();
      @(negedge clk);
      chk(rsp_vld == 1'b0, "R2 idle", rsp_vld, 0);
   endtask

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_tag[s][w] = '0; m_val[s][w] = 1'b0; m_use[s][w] = 0;
         end
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(rsp_vld == 0 && hit == 0 && blk == 0, "R1 outputs", {rsp_vld, hit}, 0);
      chk(hit_cnt == 0 && miss_cnt == 0, "R1 counters", {hit_cnt, miss_cnt}, 0);
      en = 1'b1;
      // R4 fill then hit
      access(32'h1000, 1, "R4 first");
      access(32'h1000, 1, "R4 repeat");
      // R5 second address of set 0 fills the invalid way, first stays
      access(32'h2000, 1, "R5 fill");
      access(32'h1000, 1, "R5 kept");
      idle();
      // R7 aging decides the victim
      access(32'h2000, 1, "R7 touch");
      access(32'h1000, 1, "R7 touch");
      access(32'h3000, 1, "R7 evict");
      access(32'h1000, 1, "R7 survivor");
      access(32'h2000, 1, "R6 evicted");
      // R11 traffic in set 1 leaves set 0 alone
      access(32'h1001, 1, "R11 other");
      access(32'h1001, 1, "R11 other");
      access(32'h4001, 1, "R11 other");
      access(32'h3000, 1, "R11 set0");
      access(32'h2000, 1, "R11 set0");
      // R10 disabled request is ignored
      access(32'h5000, 0, "R10 off");
      idle();
      access(32'h5000, 1, "R10 later");
      // Random traffic on a small pool of sets and tags
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] a;
         a = AW'(32'h1000 * ($urandom % 5)) + AW'($urandom % 4);
         access(a, ($urandom % 10) != 0, "R6 rand");
         if ($urandom % 4 == 0) idle();
      end
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule